// File: doc/BRIEF.md
# Match/Capture Timer-Counter

A 32-bit timer/counter with a word-addressed register bus. In timer mode a prescaler divides the system clock before it reaches the main counter. In counter mode the main counter advances on chosen edges of one of two capture inputs.

Four match registers compare against the counter. On a match each one can do any mix of three things: raise an interrupt flag, return the counter to zero, or halt counting. Each match can also drive its own output bit low, drive it high, or toggle it.

Two capture channels copy the counter value on chosen input edges, and each can raise a flag. All flags are sticky and are cleared by writing ones. The interrupt line is high while any flag is set.

Top module: `match_cap_timer`

## Requirements
- R1: After reset all registers, `match_out` and `irq` are zero. While control bit 1 is set, the counter and the prescale counter are held at zero, even when control bit 0 is also set.
- R2: In timer mode (count-control bits [1:0] = 0) with control bit 0 set, the prescale counter counts up each clock. When it equals the prescale limit it returns to 0 and the counter steps by one, so the counter steps once every limit+1 clocks.
- R3: A match on channel n happens when the counter equals match register n on a step. If bit 3n of match control is set, the match sets flag bit n, and `irq` rises.
- R4: If bit 3n+1 of match control is set, a match on channel n makes the next counter value 0 instead of match+1.
- R5: If bit 3n+2 of match control is set, a match on channel n clears control bit 0, and the counter then holds the value it stepped to.
- R6: The external match register holds the output levels in bits [3:0], which appear on `match_out` and can be written. The action field for channel n is at bits [5+2n:4+2n]: 0 keeps the level, 1 drives it to 0, 2 drives it to 1, 3 inverts it.
- R7: Capture channel c passes through two synchronizing flops. Capture control bit 3c selects rising edges and bit 3c+1 selects falling edges. On a selected edge, capture register c loads the counter. If bit 3c+2 is set, flag bit 4+c is set. An edge that is not selected leaves the capture register unchanged.
- R8: Count-control codes 1, 2 and 3 in bits [1:0] make the counter step on rising, falling or both edges of capture input 0 (bit 2 = 0) or capture input 1 (bit 2 = 1). Edges on the other input have no effect.
- R9: Writing to the flag register clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. `irq` is the OR of all flags.
- R10: Registers are addressed by word index: flags 0x00, control 0x01, counter 0x02, prescale limit 0x03, prescale counter 0x04, match control 0x05, match 0–3 at 0x06–0x09, capture control 0x0A, capture 0–1 at 0x0B–0x0C, external match 0x0F, count control 0x1C. Capture registers are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_widx | input | 5 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_widx` |
| cap_in | input | 2 | Asynchronous capture / count inputs |
| match_out | output | 4 | External match output levels |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The prescaler is run with a limit of 3 and a limit of 0. The counts after a fixed run tell a divide-by-limit+1 counter apart from an off-by-one divider.

Match channels are tried one action at a time. Reset-with-interrupt must keep the counter inside 0..5. Stop must freeze the counter at match+1. The set, clear and toggle codes act on three channels in one run, which exposes swapped or shifted action fields.

Capture is done with the counter frozen at known values. Rising, falling and unselected edges then give distinct, exact expected register contents. Counter mode is fed pulses on the selected input and on the other input, which separates the edge-select codes and the input select.

// File: rtl/match_cap_timer.sv
module match_cap_timer #(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [4:0]    bus_widx,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [NC-1:0] cap_in,
  output logic [NM-1:0] match_out,
  output logic          irq
);
  localparam int NF = NM + NC;
  localparam int EW = NM + 2*NM;

  logic [NF-1:0]   flags;
  logic [1:0]      ctl;
  logic [W-1:0]    tc, pr, pc;
  logic [3*NM-1:0] mcr;
  logic [W-1:0]    mr [NM];
  logic [3*NC-1:0] ccr;
  logic [W-1:0]    cr [NC];
  logic [EW-1:0]   emr;
  logic [2:0]      ctcr;
  logic [NC-1:0]   s1, s2, s3, rise, fall, cap_ev, cap_irq;
  logic [NM-1:0]   hit, m_int, m_rst, m_stop;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  wire run        = ctl[0] & ~ctl[1];
  wire timer_mode = (ctcr[1:0] == 2'd0);
  wire cnt_edge   = (ctcr[0] & rise[ctcr[2]]) | (ctcr[1] & fall[ctcr[2]]);
  wire tick       = run & (timer_mode ? (pc == pr) : cnt_edge);
  wire wr_ctl     = bus_wr && bus_widx == 5'h01;
  wire wr_tc      = bus_wr && bus_widx == 5'h02;
  wire do_rst     = |(hit & m_rst);
  wire do_stop    = |(hit & m_stop);

  for (genvar n = 0; n < NM; n++) begin : g_m
    assign m_int[n]  = mcr[3*n];
    assign m_rst[n]  = mcr[3*n+1];
    assign m_stop[n] = mcr[3*n+2];
    assign hit[n]    = tick && (tc == mr[n]);
  end
  for (genvar c = 0; c < NC; c++) begin : g_c
    assign cap_ev[c]  = (ccr[3*c] & rise[c]) | (ccr[3*c+1] & fall[c]);
    assign cap_irq[c] = ccr[3*c+2];
  end

  assign match_out = emr[NM-1:0];
  assign irq       = |flags;

  always_comb begin
    bus_rdata = '0;
    case (bus_widx)
      5'h00: bus_rdata[NF-1:0]   = flags;
      5'h01: bus_rdata[1:0]      = ctl;
      5'h02: bus_rdata           = tc;
      5'h03: bus_rdata           = pr;
      5'h04: bus_rdata           = pc;
      5'h05: bus_rdata[3*NM-1:0] = mcr;
      5'h0A: bus_rdata[3*NC-1:0] = ccr;
      5'h0F: bus_rdata[EW-1:0]   = emr;
      5'h1C: bus_rdata[2:0]      = ctcr;
      default: ;
    endcase
    for (int n = 0; n < NM; n++)
      if (bus_widx == 5'(6 + n)) bus_rdata = mr[n];
    for (int c = 0; c < NC; c++)
      if (bus_widx == 5'(11 + c)) bus_rdata = cr[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0; ctl <= '0; tc <= '0; pr <= '0; pc <= '0;
      mcr <= '0; ccr <= '0; emr <= '0; ctcr <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      for (int n = 0; n < NM; n++) mr[n] <= '0;
      for (int c = 0; c < NC; c++) cr[c] <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
      if (run && timer_mode) pc <= (pc == pr) ? '0 : pc + 1'b1;
      if (tick) tc <= do_rst ? '0 : tc + 1'b1;
      if (do_stop) ctl[0] <= 1'b0;
      for (int n = 0; n < NM; n++)
        if (hit[n])
          case (emr[NM+2*n +: 2])
            2'd1: emr[n] <= 1'b0;
            2'd2: emr[n] <= 1'b1;
            2'd3: emr[n] <= ~emr[n];
            default: ;
          endcase
      for (int c = 0; c < NC; c++)
        if (cap_ev[c]) cr[c] <= tc;
      flags <= (flags & ~((bus_wr && bus_widx == 5'h00) ? bus_wdata[NF-1:0] : '0))
             | {cap_ev & cap_irq, hit & m_int};
      if (bus_wr) begin
        case (bus_widx)
          5'h01: ctl  <= bus_wdata[1:0];
          5'h02: tc   <= bus_wdata;
          5'h03: pr   <= bus_wdata;
          5'h04: pc   <= bus_wdata;
          5'h05: mcr  <= bus_wdata[3*NM-1:0];
          5'h0A: ccr  <= bus_wdata[3*NC-1:0];
          5'h0F: emr  <= bus_wdata[EW-1:0];
          5'h1C: ctcr <= bus_wdata[2:0];
          default: ;
        endcase
        for (int n = 0; n < NM; n++)
          if (bus_widx == 5'(6 + n)) mr[n] <= bus_wdata;
      end
      if (ctl[1]) begin
        tc <= '0;
        pc <= '0;
      end
    end
  end

  // R1
  hold_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[1] |=> (tc == '0 && pc == '0));
  // R3
  match_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && m_int[0]) |=> (flags[0] && irq));
  // R4
  match_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rst && !wr_tc) |=> (tc == '0));
  // R5
  match_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stop && !wr_ctl) |=> !ctl[0]);
  // R2
  tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_tc && !ctl[1]) |=> $stable(tc));
endmodule

// File: tb/tb_match_cap_timer.sv
module tb_match_cap_timer;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [4:0] bus_widx = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd;
  logic [1:0] cap_in = '0;
  logic [3:0] match_out;
  logic irq;
  int total = 0, bad = 0;

  match_cap_timer dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .match_out(match_out), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_widx = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rdr(input logic [4:0] a);
    @(negedge clk); bus_widx = a; #1 rd = bus_rdata;
  endtask
  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask
  task automatic restart();
    wr(5'h01, 32'h2); wr(5'h01, 32'h1);
  endtask
  task automatic pulse(input int ch);
    @(negedge clk); cap_in[ch] = 1; repeat (4) @(negedge clk);
    cap_in[ch] = 0; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rdr(5'h01); chk("R1 ctl", rd, 0);
    rdr(5'h02); chk("R1 tc", rd, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 match_out", {28'd0, match_out}, 0);
    wr(5'h01, 32'h3); repeat (10) @(posedge clk);
    rdr(5'h02); chk("R1 hold tc", rd, 0);
    rdr(5'h04); chk("R1 hold pc", rd, 0);
    wr(5'h01, 32'h0);
  endtask

  task automatic t_prescale();
    wr(5'h03, 3); restart(); repeat (40) @(posedge clk); wr(5'h01, 0);
    rdr(5'h02); chk("R2 div4 tc", rd, 10);
    rdr(5'h04); chk("R2 div4 pc", rd, 1);
    wr(5'h03, 0); restart(); repeat (40) @(posedge clk); wr(5'h01, 0);
    rdr(5'h02); chk("R2 div1 tc", rd, 41);
  endtask

  task automatic t_match_rst();
    logic ok = 1;
    wr(5'h06, 5); wr(5'h05, 32'h3); restart();
    for (int i = 0; i < 20; i++) begin
      rdr(5'h02); if (rd > 5) ok = 0;
    end
    wr(5'h01, 0);
    chk("R4 tc within 0..5", {31'd0, ok}, 1);
    rdr(5'h00); chk("R3 flag0", rd, 1);
    chk("R3 irq", {31'd0, irq}, 1);
    wr(5'h00, 0); rdr(5'h00); chk("R9 write0 keeps", rd, 1);
    wr(5'h00, 1); rdr(5'h00); chk("R9 write1 clears", rd, 0);
    chk("R9 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_stop();
    wr(5'h07, 7); wr(5'h05, 32'h20); restart();
    repeat (30) @(posedge clk);
    rdr(5'h02); chk("R5 tc frozen", rd, 8);
    rdr(5'h01); chk("R5 enable cleared", rd, 0);
    rdr(5'h00); chk("R3 no flag without int bit", rd, 0);
  endtask

  task automatic t_ext();
    wr(5'h05, 0); wr(5'h06, 2); wr(5'h07, 3); wr(5'h08, 4);
    wr(5'h0F, 32'h362);
    chk("R6 written level", {28'd0, match_out}, 4'h2);
    restart(); repeat (10) @(posedge clk); wr(5'h01, 0);
    chk("R6 set/clear/toggle", {28'd0, match_out}, 4'h5);
    rdr(5'h0F); chk("R6 emr readback", rd, 32'h365);
  endtask

  task automatic t_capture();
    wr(5'h0A, 32'h15); wr(5'h02, 100);
    @(negedge clk); cap_in[0] = 1; repeat (5) @(negedge clk);
    rdr(5'h0B); chk("R7 rise cap0", rd, 100);
    rdr(5'h00); chk("R7 flag4", rd, 32'h10);
    wr(5'h02, 200);
    @(negedge clk); cap_in[1] = 1; repeat (5) @(negedge clk);
    rdr(5'h0C); chk("R7 rise ignored cap1", rd, 0);
    @(negedge clk); cap_in[1] = 0; repeat (5) @(negedge clk);
    rdr(5'h0C); chk("R7 fall cap1", rd, 200);
    rdr(5'h00); chk("R7 no flag5", rd, 32'h10);
    wr(5'h02, 300);
    @(negedge clk); cap_in[0] = 0; repeat (5) @(negedge clk);
    rdr(5'h0B); chk("R7 fall ignored cap0", rd, 100);
    wr(5'h00, 32'h30); wr(5'h0A, 0);
  endtask

  task automatic t_counter();
    wr(5'h1C, 1); restart();
    pulse(0); pulse(0); pulse(0); pulse(1);
    rdr(5'h02); chk("R8 rising cap0", rd, 3);
    wr(5'h1C, 7);
    pulse(0); pulse(1); pulse(1);
    wr(5'h01, 0);
    rdr(5'h02); chk("R8 both edges cap1", rd, 7);
    rdr(5'h1C); chk("R10 ctcr readback", rd, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset(); t_prescale(); t_match_rst(); t_stop(); t_ext(); t_capture(); t_counter();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule